// File: doc/BRIEF.md
# BCD Stopwatch Timer with Interrupts

The block counts elapsed time in hundredths and tenths of a second using two cascaded BCD digits. It advances on a tick enable of about 100 Hz, supplied from outside. The hundredths digit steps on every accepted tick. The tenths digit steps each time the hundredths digit rolls over. Three timing events come out of this chain:
- a fast event, at about 100 Hz, on every accepted tick;
- a medium event, at about 10 Hz, when the hundredths digit rolls over;
- a slow event, at about 1 Hz, when the tenths digit rolls over.

Each event latches its own pending flag. Software can poll these flags whether or not the source is enabled.

Software controls the block through a 4-entry register port with an 8-bit data bus. Writes are synchronous and reads are combinational.
- Control (address 0): holds the run bit and the restart strobe.
- Count (address 1): read-only BCD readback.
- Pending flags (address 2): write 1 to clear a flag.
- Configuration (address 3): holds the per-source enables and a shared 2-bit interrupt level.

On the interrupt side, the block drives three outputs:
- a combined request;
- the configured level;
- the vector address of the most urgent enabled pending source.

The slow source is the most urgent, then the medium source, then the fast source.

Top module: `swtimer_top`

## Requirements
- R1: After synchronous active-low reset, the count is 0x00, all flags, enables, the level and the run bit read 0, `irq_o` is 0 and `irq_vector_o` is 0.
- R2: The hundredths digit (count register bits [3:0]) steps by one on each accepted tick, counting 0 to 9 and returning to 0. The update is visible on the cycle after the tick.
- R3: The tenths digit (count register bits [7:4]) steps by one only on the tick where hundredths returns from 9 to 0. It counts 0 to 9 and returns to 0.
- R4: On an accepted tick, flag bit 0 sets. On a hundredths rollover, flag bit 1 sets. On a tenths rollover, flag bit 2 sets. Flags are read at address 2 and set regardless of their enable bits.
- R5: Writing 1 to a bit of address 2 clears that flag, and writing 0 leaves it unchanged. When a set event and a clear hit the same flag in the same cycle, the flag ends up set.
- R6: `irq_o` is the OR of all flags whose enable bit (address 3 bits [2:0], same bit order as the flags) is 1, qualified by a nonzero level.
- R7: `irq_level_o` presents address 3 bits [5:4]. When this level is 0, `irq_o` is held at 0.
- R8: `irq_vector_o` reports the most urgent enabled pending flag: 0x00001A for bit 2, 0x000018 for bit 1, 0x000016 for bit 0. When no enabled flag is pending, it reports 0.
- R9: While the run bit (address 0 bit 0) is 0, ticks are ignored: the count holds and no flag sets.
- R10: Writing address 0 with bit 1 set clears both digits in that cycle. A tick arriving in the same cycle is discarded and sets no flag.
- R11: Writes to address 1 are ignored. Address 0 reads back the run bit in bit 0, and bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | About 100 Hz count enable, one cycle wide |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| irq_o | output | 1 | Combined interrupt request |
| irq_level_o | output | 2 | Configured interrupt level |
| irq_vector_o | output | 24 | Vector address of the most urgent enabled pending source |

## Verification
The in-RTL assertions check on every cycle that:
- each digit stays within 0 to 9, steps by exactly one and returns to 0 on rollover;
- a set event always leaves its flag high;
- a clear without a set drops it;
- a zero level mutes the request, and a request never appears without an enabled pending flag;
- the count holds while stopped and is zero after a restart.

Only the bench scenarios can show the following behaviours:
- the exact rollover cycles over a full 100-tick period;
- vector ordering with several flags pending;
- the set-over-clear race driven from the register port;
- the ignored count write;
- the restart discarding a coincident tick.

// File: rtl/sw_pkg.sv
// Package: shared register decode and field positions for the stopwatch timer.
// Assumes a 2-bit register address space.
package sw_pkg;
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_FLAGS = 2'd2,
        REG_CFG   = 2'd3
    } sw_reg_e;

    localparam int CTRL_RUN_BIT     = 0;
    localparam int CTRL_RESTART_BIT = 1;
    localparam int CFG_LEVEL_POS    = 4;
endpackage

// File: rtl/sw_bcd_digit.sv
// Module: one decimal counter digit of the stopwatch chain.
// Steps on inc_i, returns to 0 after DIGIT_MAX and flags that rollover on
// wrap_o in the same cycle. clear_i has precedence over inc_i.
// Assumes DIGIT_MAX fits in DIGIT_W bits.
module sw_bcd_digit #(
    parameter int DIGIT_W   = 4,
    parameter int DIGIT_MAX = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               inc_i,
    output logic [DIGIT_W-1:0] value_o,
    output logic               wrap_o
);
    localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(DIGIT_MAX);

    // Rollover indication towards the next digit and the event logic.
    assign wrap_o = inc_i && !clear_i && (value_o == TOP);

    // Digit state: clear, then step with rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_o <= '0;
        end else if (clear_i) begin
            value_o <= '0;
        end else if (inc_i) begin
            value_o <= (value_o == TOP) ? '0 : value_o + 1'b1;
        end
    end

    // R2
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        value_o <= TOP);
    // R3
    digit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (value_o == '0));
    // R2
    digit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clear_i && value_o != TOP) |=> (value_o == DIGIT_W'($past(value_o) + 1'b1)));
endmodule

// File: rtl/sw_irq_unit.sv
// Module: pending flags, request qualification and vector selection.
// Each flag is set by its event (set wins) and cleared by a write-1 strobe.
// The highest-indexed enabled pending flag selects the vector
// VEC_BASE + VEC_STEP*index. A zero level mutes the request.
module sw_irq_unit #(
    parameter int NUM_SRC  = 3,
    parameter int PRIO_W   = 2,
    parameter int VEC_W    = 24,
    parameter int VEC_BASE = 'h16,
    parameter int VEC_STEP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [PRIO_W-1:0]  prio_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vector_o
);
    logic [NUM_SRC-1:0] pending;

    // One flag register per source.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
        // Flag k: set has precedence over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_o[k] <= 1'b0;
            end else if (set_i[k]) begin
                flags_o[k] <= 1'b1;
            end else if (clr_i[k]) begin
                flags_o[k] <= 1'b0;
            end
        end
    end

    assign pending = flags_o & en_i;
    assign irq_o   = (|pending) && (prio_i != '0);

    // Vector selection: later (more urgent) sources override earlier ones.
    always_comb begin
        vector_o = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (pending[k]) begin
                vector_o = VEC_W'(VEC_BASE + VEC_STEP * k);
            end
        end
    end

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));
    // R5
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));
    // R7
    irq_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_i == '0) |-> !irq_o);
    // R6
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(flags_o & en_i)));
    // R8
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & en_i) == '0) |-> (vector_o == '0));
    // R8
    vec_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[NUM_SRC-1] && en_i[NUM_SRC-1]) |->
            (vector_o == VEC_W'(VEC_BASE + VEC_STEP * (NUM_SRC - 1))));
endmodule

// File: rtl/swtimer_top.sv
// Module: BCD stopwatch timer with three rollover-driven interrupt sources.
// A run-gated tick drives a chain of NUM_DIGITS decimal digits. The tick and
// each digit rollover form the event sources. A small register port exposes
// control, count, flags and configuration.
// Assumes tick_i is a single-cycle enable at about 100 Hz and that
// NUM_DIGITS*DIGIT_W fits in DATA_W.
module swtimer_top
    import sw_pkg::*;
#(
    parameter int DIGIT_W    = 4,
    parameter int DIGIT_MAX  = 9,
    parameter int NUM_DIGITS = 2,
    parameter int ADDR_W     = 2,
    parameter int DATA_W     = 8,
    parameter int PRIO_W     = 2,
    parameter int VEC_W      = 24,
    parameter int VEC_BASE   = 'h16,
    parameter int VEC_STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic [PRIO_W-1:0] irq_level_o,
    output logic [VEC_W-1:0]  irq_vector_o
);
    localparam int NUM_SRC = NUM_DIGITS + 1;

    sw_reg_e                                reg_sel;
    logic                                   run_q;
    logic [NUM_SRC-1:0]                     en_q;
    logic [PRIO_W-1:0]                      prio_q;
    logic                                   restart;
    logic [NUM_SRC-1:0]                     events;
    logic [NUM_DIGITS-1:0][DIGIT_W-1:0]     digits;
    logic [NUM_SRC-1:0]                     flags;
    logic [NUM_SRC-1:0]                     flag_clr;
    logic                                   unused_wdata;

    assign reg_sel      = sw_reg_e'(reg_addr_i);
    assign unused_wdata = ^reg_wdata_i;
    assign restart      = reg_wr_i && (reg_sel == REG_CTRL) && reg_wdata_i[CTRL_RESTART_BIT];
    assign flag_clr     = (reg_wr_i && reg_sel == REG_FLAGS) ? reg_wdata_i[NUM_SRC-1:0] : '0;

    // Fast event: an accepted tick; a restart discards a coincident tick.
    assign events[0] = tick_i && run_q && !restart;

    // Digit chain: each digit's rollover drives the next digit and event.
    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        sw_bcd_digit #(
            .DIGIT_W  (DIGIT_W),
            .DIGIT_MAX(DIGIT_MAX)
        ) u_digit (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear_i(restart),
            .inc_i  (events[d]),
            .value_o(digits[d]),
            .wrap_o (events[d+1])
        );
    end

    // Control and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            en_q   <= '0;
            prio_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_sel == REG_CTRL) begin
                run_q <= reg_wdata_i[CTRL_RUN_BIT];
            end
            if (reg_sel == REG_CFG) begin
                en_q   <= reg_wdata_i[NUM_SRC-1:0];
                prio_q <= reg_wdata_i[CFG_LEVEL_POS +: PRIO_W];
            end
        end
    end

    sw_irq_unit #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .VEC_W   (VEC_W),
        .VEC_BASE(VEC_BASE),
        .VEC_STEP(VEC_STEP)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (events),
        .clr_i   (flag_clr),
        .en_i    (en_q),
        .prio_i  (prio_q),
        .flags_o (flags),
        .irq_o   (irq_o),
        .vector_o(irq_vector_o)
    );

    assign irq_level_o = prio_q;

    // Read multiplexer.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_sel)
            REG_CTRL:  reg_rdata_o[CTRL_RUN_BIT] = run_q;
            REG_COUNT: reg_rdata_o = DATA_W'(digits);
            REG_FLAGS: reg_rdata_o = DATA_W'(flags);
            REG_CFG: begin
                reg_rdata_o[NUM_SRC-1:0]                 = en_q;
                reg_rdata_o[CFG_LEVEL_POS +: PRIO_W]     = prio_q;
            end
            default:   reg_rdata_o = '0;
        endcase
    end

    // R9
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !restart) |=> $stable(digits));
    // R10
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (digits == '0));
    // R10
    restart_noevent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (events == '0));
endmodule

// File: tb/tb_swtimer_top.sv
`timescale 1ns/1ps
module tb_swtimer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic [7:0]  reg_wdata_i = '0;
    logic [7:0]  reg_rdata_o;
    logic        irq_o;
    logic [1:0]  irq_level_o;
    logic [23:0] irq_vector_o;

    swtimer_top dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .irq_o(irq_o), .irq_level_o(irq_level_o), .irq_vector_o(irq_vector_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          kind;
        logic [23:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    int unsigned m_hund = 0, m_tenth = 0, m_run = 0, m_prio = 0;
    logic [2:0] m_flags = '0, m_en = '0;

    // Monitor: pop expected items and compare against the live outputs.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [23:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = {16'h0, reg_rdata_o};
                1: act = {23'h0, irq_o};
                2: act = {22'h0, irq_level_o};
                default: act = irq_vector_o;
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_item(int kind, logic [1:0] a, logic [23:0] e, string tag);
        reg_addr_i = a;
        q.push_back('{kind, e, tag});
        @(negedge clk);
        #1;
    endtask

    task automatic model_tick();
        m_flags[0] = 1'b1;
        if (m_hund == 9) begin
            m_hund = 0;
            m_flags[1] = 1'b1;
            if (m_tenth == 9) begin
                m_tenth = 0;
                m_flags[2] = 1'b1;
            end else m_tenth++;
        end else m_hund++;
    endtask

    task automatic model_write(logic [1:0] a, logic [7:0] d);
        case (a)
            2'd0: begin
                m_run = d[0];
                if (d[1]) begin m_hund = 0; m_tenth = 0; end
            end
            2'd2: m_flags = m_flags & ~d[2:0];
            2'd3: begin m_en = d[2:0]; m_prio = d[5:4]; end
            default: ;
        endcase
    endtask

    // Write, optionally with a coincident tick.
    task automatic wr(logic [1:0] a, logic [7:0] d, bit with_tick = 0);
        bit restart;
        int unsigned old_run;
        restart = (a == 2'd0) && d[1];
        old_run = m_run;
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; tick_i = with_tick;
        model_write(a, d);
        if (with_tick && !restart && old_run != 0) model_tick();
        step();
        reg_wr_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            if (m_run != 0) model_tick();
            step();
            tick_i = 1'b0;
        end
    endtask

    function automatic logic [23:0] exp_vec();
        logic [2:0] p;
        p = m_flags & m_en;
        if (p[2]) return 24'h1A;
        if (p[1]) return 24'h18;
        if (p[0]) return 24'h16;
        return 24'h0;
    endfunction

    function automatic logic [23:0] exp_req();
        return {23'h0, (|(m_flags & m_en)) && (m_prio != 0)};
    endfunction

    task automatic check_state(string tag);
        expect_item(0, 2'd1, {16'h0, 4'(m_tenth), 4'(m_hund)}, {tag, " count"});
        expect_item(0, 2'd2, {21'h0, m_flags}, {tag, " flags"});
        expect_item(1, 2'd0, exp_req(), {tag, " irq"});
        expect_item(3, 2'd0, exp_vec(), {tag, " vector"});
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        check_state("R1 reset");
        expect_item(0, 2'd0, 24'h0, "R1 ctrl");
        expect_item(0, 2'd3, 24'h0, "R1 cfg");
        expect_item(2, 2'd0, 24'h0, "R1 level");
        // R9: ticks ignored while stopped
        tick(3);
        check_state("R9 stopped");
        // R2/R4: run and count five ticks
        wr(2'd0, 8'h01);
        tick(5);
        check_state("R2 R4 five ticks");
        // R7: level 0 mutes request; R8 vector still shown
        wr(2'd3, 8'h01);
        check_state("R7 level zero");
        expect_item(2, 2'd0, 24'h0, "R7 level out 0");
        wr(2'd3, 8'h21);
        check_state("R6 R7 level two");
        expect_item(2, 2'd0, 24'h2, "R7 level out 2");
        expect_item(0, 2'd3, 24'h21, "R7 cfg readback");
        // R5: write 0 keeps, write 1 clears
        wr(2'd2, 8'h00);
        check_state("R5 write zero");
        wr(2'd2, 8'h01);
        check_state("R5 write one");
        // R3/R4: hundredths rollover
        tick(5);
        check_state("R3 R4 hundredths wrap");
        wr(2'd3, 8'h27);
        check_state("R8 medium first");
        // R11: count write ignored
        wr(2'd1, 8'hFF);
        check_state("R11 count write");
        // R3/R4/R8: tenths rollover after 100 ticks in total
        tick(90);
        check_state("R3 R8 tenths wrap");
        // R5: set wins over clear
        wr(2'd2, 8'h07);
        check_state("R5 clear all");
        wr(2'd2, 8'h01, 1);
        check_state("R5 set wins");
        // R10: restart discards a coincident tick
        wr(2'd2, 8'h07);
        tick(3);
        wr(2'd2, 8'h07);
        wr(2'd0, 8'h03, 1);
        check_state("R10 restart");
        expect_item(0, 2'd0, 24'h01, "R11 ctrl readback");
        // R9: stop again
        wr(2'd0, 8'h00);
        tick(4);
        check_state("R9 stopped again");
        // R6: pending flags with enables off give no request
        wr(2'd0, 8'h01);
        tick(1);
        wr(2'd3, 8'h30);
        check_state("R6 enables off");
        expect_item(2, 2'd0, 24'h3, "R7 level out 3");
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule